// File: doc/BRIEF.md
# Square-Wave Path-Delay Test Controller

This block runs an at-speed path-delay test on a programmed logic network. It drives every primary input of the circuit under test with a square wave that flips on each clock. It then watches the circuit's outputs and decides whether any path was too slow to carry its transition. A test begins with a start pulse.

At the start pulse the block captures its configuration:

- the largest number of flip-flops on any path (the depth);
- a phase bit for each input;
- a phase bit for each output;
- the phase of the deepest path's first and last node;
- the network mode.

From these it works out the first value of every input wave and the cycle in which each output is observed. The test runs for depth + 2 cycles. Each output is compared once against the value a fault-free network must show, and a sticky per-output fail mask is kept. One cycle after the last test cycle the block pulses `done`, together with a pass flag and the fail mask.

Working out the masks and programming the device happen outside this block.

Top module: `swt_delay_test`

## Requirements
- R1: While `rst_n` is low, `cut_in`, `busy`, `done`, `pass` and `fail_mask` are all zero.
- R2: A `start` seen while idle makes `busy` high from the next cycle for exactly depth + 2 cycles, numbered 1 to depth + 2. In cycle 1 `cut_in` holds the initial vector. `done` rises in the cycle right after the last one, as `busy` falls.
- R3: During the run, every bit of `cut_in` inverts on every cycle after cycle 1.
- R4: Mode code 2'b00 is the AND network. In this mode, an input whose `in_phase` bit equals `ref_in_phase` starts at 0, and any other input starts at 1.
- R5: Mode code 2'b01 is the OR network. In this mode, an input whose `in_phase` bit equals `ref_in_phase` starts at 1, and any other input starts at 0.
- R6: Mode codes 2'b10 (sensitized, rising) and 2'b11 (sensitized, falling) ignore `in_phase`. In these modes all inputs start equal: bit 0 of `depth` for rising, its inverse for falling.
- R7: Output j is observed only in cycle depth + 2 if `out_phase[j]` equals `ref_out_phase`, and only in cycle depth + 1 otherwise. Its value in every other cycle has no effect on the result.
- R8: The fault-free value is 1 for modes 2'b00 and 2'b10 and 0 for modes 2'b01 and 2'b11. A mismatch at the observation cycle of output j sets `fail_mask[j]`.
- R9: `done` is high for one cycle only. In that cycle `pass` is 1 exactly when `fail_mask` is all zero. `pass` and `fail_mask` keep their values until the next accepted start.
- R10: After the last test cycle, `cut_in` holds the final vector until the next accepted start.
- R11: A `start` pulse while `busy` is high has no effect: the running test's length, waves and result are unchanged.
- R12: A depth of 0 gives a 2-cycle test. Outputs in phase with `ref_out_phase` are observed in cycle 2, and the others in cycle 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only while idle |
| depth | input | DEPTH_W | Maximum sequential depth of the circuit under test |
| mode | input | 2 | Network mode code (see R4 to R6) |
| in_phase | input | NUM_IN | Phase bit per driven input |
| ref_in_phase | input | 1 | Phase of the deepest path's start node |
| out_phase | input | NUM_OUT | Phase bit per observed output |
| ref_out_phase | input | 1 | Phase of the deepest path's end node |
| cut_out | input | NUM_OUT | Outputs of the circuit under test |
| cut_in | output | NUM_IN | Square-wave drive to the circuit under test |
| busy | output | 1 | High during test cycles 1 to depth + 2 |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Registered pass flag |
| fail_mask | output | NUM_OUT | Per-output failure flags |

## Verification
The first driven vector appears on `cut_in` one cycle after `start` is sampled, and each later vector one cycle after the one before it. The bench checks `cut_in` at the falling edge within each of the depth + 2 test cycles, against a vector computed from the mode, the phase masks and the cycle number. Values on `cut_out` are driven at the falling edge of cycle k and captured at the rising edge that closes it. `done`, `pass` and `fail_mask` are therefore due exactly one cycle after cycle depth + 2. The bench reads them at that falling edge, and again one cycle later to confirm that the pulse has ended and the result is held.

// File: rtl/swt_pkg.sv
package swt_pkg;

   typedef enum logic [1:0] {
      NET_AND   = 2'b00,
      NET_OR    = 2'b01,
      SENS_RISE = 2'b10,
      SENS_FALL = 2'b11
   } net_mode_e;

   // Fault-free observed level for a network mode
   function automatic logic good_level(input net_mode_e m);
      return (m == NET_AND) || (m == SENS_RISE);
   endfunction

endpackage

// File: rtl/swt_ctrl.sv
module swt_ctrl #(
   parameter int DEPTH_W = 6,
   localparam int CNT_W  = DEPTH_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [DEPTH_W-1:0] depth,
   output logic               load,
   output logic               busy,
   output logic               last,
   output logic               done,
   output logic [CNT_W-1:0]   cnt,
   output logic [CNT_W-1:0]   len
);

   logic busy_q;
   logic done_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_q;

   assign load = start & ~busy_q;
   assign last = busy_q & (cnt_q == len_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
         len_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (load) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(1);
            len_q  <= {1'b0, depth} + CNT_W'(2);
         end else if (busy_q) begin
            if (last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
   assign cnt  = cnt_q;
   assign len  = len_q;

endmodule

// File: rtl/swt_seq_gen.sv
module swt_seq_gen
   import swt_pkg::*;
#(
   parameter int NUM_IN = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  net_mode_e         mode,
   input  logic [NUM_IN-1:0] in_phase,
   input  logic              ref_in,
   input  logic              depth_lsb,
   output logic [NUM_IN-1:0] wave
);

   logic [NUM_IN-1:0] seed;
   logic [NUM_IN-1:0] wave_q;

   for (genvar i = 0; i < NUM_IN; i++) begin : g_seed
      logic off_phase;
      assign off_phase = in_phase[i] ^ ref_in;
      always_comb begin
         unique case (mode)
            NET_AND:   seed[i] = off_phase;
            NET_OR:    seed[i] = ~off_phase;
            SENS_RISE: seed[i] = depth_lsb;
            default:   seed[i] = ~depth_lsb;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wave_q <= '0;
      end else if (load) begin
         wave_q <= seed;
      end else if (step) begin
         wave_q <= ~wave_q;
      end
   end

   assign wave = wave_q;

endmodule

// File: rtl/swt_obs.sv
module swt_obs
   import swt_pkg::*;
#(
   parameter int NUM_OUT = 6,
   parameter int CNT_W   = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               busy,
   input  logic [CNT_W-1:0]   cnt,
   input  logic [CNT_W-1:0]   len,
   input  net_mode_e          mode,
   input  logic [NUM_OUT-1:0] out_phase,
   input  logic               ref_out,
   input  logic [NUM_OUT-1:0] cut_out,
   output logic [NUM_OUT-1:0] fail_mask,
   output logic               pass
);

   logic [NUM_OUT-1:0] late_q;
   logic               good_q;
   logic [NUM_OUT-1:0] fail_q;
   logic [NUM_OUT-1:0] fail_nxt;
   logic               pass_q;
   logic               at_end;
   logic               at_early;

   assign at_end   = busy && (cnt == len);
   assign at_early = busy && (cnt == (len - CNT_W'(1)));

   for (genvar j = 0; j < NUM_OUT; j++) begin : g_lane
      logic hit;
      assign hit         = late_q[j] ? at_end : at_early;
      assign fail_nxt[j] = fail_q[j] | (hit & (cut_out[j] ^ good_q));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         late_q <= '0;
         good_q <= 1'b0;
         fail_q <= '0;
         pass_q <= 1'b0;
      end else if (load) begin
         late_q <= ~(out_phase ^ {NUM_OUT{ref_out}});
         good_q <= good_level(mode);
         fail_q <= '0;
         pass_q <= 1'b0;
      end else begin
         fail_q <= fail_nxt;
         if (at_end) pass_q <= ~|fail_nxt;
      end
   end

   assign fail_mask = fail_q;
   assign pass      = pass_q;

endmodule

// File: rtl/swt_delay_test.sv
module swt_delay_test
   import swt_pkg::*;
#(
   parameter int NUM_IN  = 8,
   parameter int NUM_OUT = 6,
   parameter int DEPTH_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [DEPTH_W-1:0] depth,
   input  logic [1:0]         mode,
   input  logic [NUM_IN-1:0]  in_phase,
   input  logic               ref_in_phase,
   input  logic [NUM_OUT-1:0] out_phase,
   input  logic               ref_out_phase,
   input  logic [NUM_OUT-1:0] cut_out,
   output logic [NUM_IN-1:0]  cut_in,
   output logic               busy,
   output logic               done,
   output logic               pass,
   output logic [NUM_OUT-1:0] fail_mask
);

   localparam int CNT_W = DEPTH_W + 1;

   if (NUM_IN < 1) begin : g_bad_in
      $error("swt_delay_test: NUM_IN must be at least 1");
   end
   if (NUM_OUT < 1) begin : g_bad_out
      $error("swt_delay_test: NUM_OUT must be at least 1");
   end
   if (DEPTH_W < 1 || DEPTH_W > 16) begin : g_bad_depth
      $error("swt_delay_test: DEPTH_W must be in 1..16");
   end

   net_mode_e        mode_e;
   logic             load;
   logic             last;
   logic [CNT_W-1:0] cyc_cnt;
   logic [CNT_W-1:0] test_len;

   assign mode_e = net_mode_e'(mode);

   swt_ctrl #(.DEPTH_W(DEPTH_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .depth (depth),
      .load  (load),
      .busy  (busy),
      .last  (last),
      .done  (done),
      .cnt   (cyc_cnt),
      .len   (test_len)
   );

   swt_seq_gen #(.NUM_IN(NUM_IN)) u_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .step      (busy & ~last),
      .mode      (mode_e),
      .in_phase  (in_phase),
      .ref_in    (ref_in_phase),
      .depth_lsb (depth[0]),
      .wave      (cut_in)
   );

   swt_obs #(.NUM_OUT(NUM_OUT), .CNT_W(CNT_W)) u_obs (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .busy      (busy),
      .cnt       (cyc_cnt),
      .len       (test_len),
      .mode      (mode_e),
      .out_phase (out_phase),
      .ref_out   (ref_out_phase),
      .cut_out   (cut_out),
      .fail_mask (fail_mask),
      .pass      (pass)
   );

endmodule

// File: rtl/swt_delay_test_chk.sv
module swt_delay_test_chk #(
   parameter int NUM_IN  = 8,
   parameter int NUM_OUT = 6,
   parameter int CNT_W   = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               busy,
   input logic               done,
   input logic               pass,
   input logic [NUM_IN-1:0]  cut_in,
   input logic [NUM_OUT-1:0] fail_mask,
   input logic [CNT_W-1:0]   cyc_cnt,
   input logic [CNT_W-1:0]   test_len
);

   // R3
   toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (cut_in == ~$past(cut_in)));

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> $stable(cut_in));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R11
   ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && cyc_cnt != test_len) |=>
         (busy && cyc_cnt == $past(cyc_cnt) + CNT_W'(1)));

   // R9
   pass_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pass == (fail_mask == '0)));

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cyc_cnt >= CNT_W'(1) && cyc_cnt <= test_len));

endmodule

bind swt_delay_test swt_delay_test_chk #(
   .NUM_IN  (NUM_IN),
   .NUM_OUT (NUM_OUT),
   .CNT_W   (DEPTH_W + 1)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .pass      (pass),
   .cut_in    (cut_in),
   .fail_mask (fail_mask),
   .cyc_cnt   (cyc_cnt),
   .test_len  (test_len)
);

// File: tb/tb_swt_delay_test.sv
`timescale 1ns/1ps
module tb_swt_delay_test;

   localparam int NI = 8;
   localparam int NO = 6;
   localparam int DW = 6;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic [DW-1:0] depth;
   logic [1:0]    mode;
   logic [NI-1:0] in_phase;
   logic          ref_in_phase;
   logic [NO-1:0] out_phase;
   logic          ref_out_phase;
   logic [NO-1:0] cut_out;
   logic [NI-1:0] cut_in;
   logic          busy, done, pass;
   logic [NO-1:0] fail_mask;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   swt_delay_test #(.NUM_IN(NI), .NUM_OUT(NO), .DEPTH_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .depth(depth), .mode(mode),
      .in_phase(in_phase), .ref_in_phase(ref_in_phase),
      .out_phase(out_phase), .ref_out_phase(ref_out_phase),
      .cut_out(cut_out), .cut_in(cut_in), .busy(busy), .done(done),
      .pass(pass), .fail_mask(fail_mask)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [NI-1:0] f_init(input logic [1:0] md, input logic [NI-1:0] ip,
                                            input logic ri, input int dp);
      case (md)
         2'b00:   return ip ^ {NI{ri}};
         2'b01:   return ~(ip ^ {NI{ri}});
         2'b10:   return {NI{dp[0]}};
         default: return {NI{~dp[0]}};
      endcase
   endfunction

   function automatic logic f_good(input logic [1:0] md);
      return (md == 2'b00) || (md == 2'b10);
   endfunction

   function automatic string f_req(input logic [1:0] md);
      case (md)
         2'b00:   return "R4";
         2'b01:   return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic run_test(input int dp, input logic [1:0] md, input logic [NI-1:0] ip,
                           input logic ri, input logic [NO-1:0] op, input logic ro,
                           input logic [NO-1:0] flt, input bit poke);
      int L;
      logic [NI-1:0] init, vec;
      logic g;
      L = dp + 2;
      init = f_init(md, ip, ri, dp);
      g = f_good(md);
      depth = DW'(dp); mode = md; in_phase = ip; ref_in_phase = ri;
      out_phase = op; ref_out_phase = ro;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      vec = init;
      for (int k = 1; k <= L; k++) begin
         vec = (k % 2 == 0) ? ~init : init;
         chk(busy == 1'b1, (dp == 0) ? "R12" : "R2", "busy in test cycle", 64'(busy), 64'd1);
         chk(cut_in == vec, (k == 1) ? f_req(md) : "R3", "cut_in vector", 64'(cut_in), 64'(vec));
         for (int j = 0; j < NO; j++) begin
            int sc;
            sc = (op[j] == ro) ? L : L - 1;
            cut_out[j] = (k == sc) ? (g ^ flt[j]) : 1'($urandom);
         end
         start = (poke && k == 2) ? 1'b1 : 1'b0;
         @(negedge clk);
      end
      start = 1'b0;
      chk(done == 1'b1, (dp == 0) ? "R12" : "R2", "done after last cycle", 64'(done), 64'd1);
      chk(busy == 1'b0, poke ? "R11" : "R2", "busy after run", 64'(busy), 64'd0);
      chk(fail_mask == flt, (dp == 0) ? "R12" : "R7", "fail_mask", 64'(fail_mask), 64'(flt));
      chk(pass == (flt == '0), "R8", "pass", 64'(pass), 64'(flt == '0));
      chk(cut_in == vec, "R10", "held vector", 64'(cut_in), 64'(vec));
      cut_out = NO'($urandom);
      @(negedge clk);
      chk(done == 1'b0, "R9", "done pulse width", 64'(done), 64'd0);
      chk(fail_mask == flt && pass == (flt == '0), "R9", "result held",
          64'(fail_mask), 64'(flt));
      chk(cut_in == vec, "R10", "held vector later", 64'(cut_in), 64'(vec));
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0; start = 1'b0; depth = '0; mode = 2'b00;
      in_phase = '0; ref_in_phase = 1'b0; out_phase = '0; ref_out_phase = 1'b0;
      cut_out = '0;
      repeat (3) @(negedge clk);
      // R1
      chk(cut_in == '0 && busy == 1'b0 && done == 1'b0, "R1", "reset outputs",
          64'({cut_in, busy, done}), 64'd0);
      chk(pass == 1'b0 && fail_mask == '0, "R1", "reset result",
          64'({pass, fail_mask}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corners
      run_test(0,  2'b00, 8'hA5, 1'b1, 6'b101100, 1'b0, 6'b000000, 0); // R12 pass
      run_test(0,  2'b01, 8'h3C, 1'b0, 6'b010011, 1'b1, 6'b100001, 0); // R12 fail
      run_test(63, 2'b01, 8'hF0, 1'b1, 6'b111000, 1'b1, 6'b000100, 0); // R5 deep
      run_test(5,  2'b10, 8'h12, 1'b0, 6'b001111, 1'b0, 6'b000000, 0); // R6 odd depth
      run_test(4,  2'b10, 8'hFF, 1'b1, 6'b110000, 1'b1, 6'b010000, 0); // R6 even depth
      run_test(4,  2'b11, 8'h00, 1'b0, 6'b000001, 1'b0, 6'b000010, 0); // R6 falling
      run_test(7,  2'b00, 8'h5A, 1'b0, 6'b101010, 1'b1, 6'b111111, 1); // R11 poke
      for (int n = 0; n < 40; n++) begin
         logic [NO-1:0] f;
         f = ($urandom % 2 == 0) ? '0 : NO'($urandom);
         run_test(int'($urandom % 64), 2'($urandom), NI'($urandom), 1'($urandom),
                  NO'($urandom), 1'($urandom), f, bit'($urandom % 4 == 0));
      end
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule